// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block keeps the pending interrupt sources of a 16550-style serial port and reports the most urgent one. Five conditions feed it: a receiver line error, the receive FIFO reaching its trigger level, a character timeout, the transmit FIFO running empty, and a modem-status change. The surrounding register file sends it single-cycle strobes when software reads the line status register, reads the receive FIFO, reads the identification register, writes the transmit FIFO or reads the modem status register. Each strobe retires the source that it belongs to.

The identification byte is presented on a 32-bit read port at all times, so the bus decoder only has to route it. The same state drives one active-high interrupt line. A four-bit enable mask hides sources from both outputs. A hidden source still records its event and shows up once it is enabled again.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the read port holds 0x000000C1 and `irq` is low.
- R2: Bits 31:8 of `iir_rdata` always read 0, bits 7:6 always read 11 and bits 5:4 always read 00.
- R3: Bits 3:0 carry the source code: 0001 none, 0110 line error, 0100 receive data, 1100 timeout, 0010 transmit empty, 0000 modem. The order from most to least urgent is line error, then receive data and timeout (timeout code wins over receive data), then transmit empty, then modem.
- R4: A pulse on `line_err` makes the line-error source pending from the next cycle. It stays pending until a cycle with `rd_lsr` high, and it is gone in the cycle after that.
- R5: The receive-data source follows `rx_at_level` in the same cycle. It is not latched, so it is shown again after a receive FIFO read for as long as the level stays high.
- R6: A pulse on `rx_timeout` latches the timeout source, which reports 1100 from the next cycle even while receive data is held. It clears after a cycle with `rd_rxf` high.
- R7: The transmit-empty source latches at the edge where `tx_empty` rises. It also latches at the edge where enable bit 1 goes from 0 to 1 while `tx_empty` is high. A cycle with `wr_txf` clears it.
- R8: A cycle with `rd_iir` clears the transmit-empty source only if that cycle's code was 0010. Otherwise the source stays pending.
- R9: A pulse on `modem_chg` latches the modem source from the next cycle. A cycle with `rd_msr` clears it.
- R10: `irq_en` bit 0 enables receive data and timeout, bit 1 transmit empty, bit 2 line error and bit 3 modem. A disabled source is left out of the code and of `irq`, but it still latches and appears once it is enabled.
- R11: `irq` is high exactly when bit 0 of `iir_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_err | input | 1 | Receiver line error event pulse |
| rx_at_level | input | 1 | Receive FIFO at or above trigger level |
| rx_timeout | input | 1 | Character timeout event pulse |
| tx_empty | input | 1 | Transmit FIFO empty level |
| modem_chg | input | 1 | Modem status change event pulse |
| irq_en | input | 4 | Source enables: 0 rx/timeout, 1 tx empty, 2 line, 3 modem |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rxf | input | 1 | Receive FIFO read strobe |
| rd_iir | input | 1 | Identification register read strobe |
| wr_txf | input | 1 | Transmit FIFO write strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| iir_rdata | output | 32 | Identification word |
| irq | output | 1 | Active-high interrupt request |

## Verification
The scenarios raise two or more sources at once and then retire them one by one. At every step the reported code shows whether the priority order is right. An identification read is issued once while receive data hides the transmit-empty source and once while transmit-empty is the source reported, which separates a conditional clear from one that always fires. The receive level is held high across a receive FIFO read, which tells level tracking apart from a latch. The enable mask is toggled while the transmit FIFO stays empty and while a line error is hidden, which checks the latch on an enable rise and that hidden sources keep their state.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_err,
  input  logic              rx_at_level,
  input  logic              rx_timeout,
  input  logic              tx_empty,
  input  logic              modem_chg,
  input  logic [3:0]        irq_en,
  input  logic              rd_lsr,
  input  logic              rd_rxf,
  input  logic              rd_iir,
  input  logic              wr_txf,
  input  logic              rd_msr,
  output logic [WORD_W-1:0] iir_rdata,
  output logic              irq
);
  localparam logic [3:0] C_NONE  = 4'b0001;
  localparam logic [3:0] C_LINE  = 4'b0110;
  localparam logic [3:0] C_RXD   = 4'b0100;
  localparam logic [3:0] C_TMO   = 4'b1100;
  localparam logic [3:0] C_TXE   = 4'b0010;
  localparam logic [3:0] C_MODEM = 4'b0000;
  localparam logic [3:0] UPPER   = 4'b1100;

  logic line_p, tmo_p, txe_p, mdm_p;
  logic txe_q, txen_q;
  logic [3:0] code;

  wire en_rx   = irq_en[0];
  wire en_tx   = irq_en[1];
  wire en_line = irq_en[2];
  wire en_mdm  = irq_en[3];

  wire txe_set = tx_empty && (!txe_q || (en_tx && !txen_q));
  wire txe_clr = wr_txf || (rd_iir && code == C_TXE);

  always_comb begin
    if (en_line && line_p)               code = C_LINE;
    else if (en_rx && tmo_p)             code = C_TMO;
    else if (en_rx && rx_at_level)       code = C_RXD;
    else if (en_tx && txe_p)             code = C_TXE;
    else if (en_mdm && mdm_p)            code = C_MODEM;
    else                                 code = C_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_p <= 1'b0;
      tmo_p  <= 1'b0;
      txe_p  <= 1'b0;
      mdm_p  <= 1'b0;
      txe_q  <= 1'b0;
      txen_q <= 1'b0;
    end else begin
      txe_q  <= tx_empty;
      txen_q <= en_tx;
      if (line_err)        line_p <= 1'b1;
      else if (rd_lsr)     line_p <= 1'b0;
      if (rx_timeout)      tmo_p <= 1'b1;
      else if (rd_rxf)     tmo_p <= 1'b0;
      if (txe_set)         txe_p <= 1'b1;
      else if (txe_clr)    txe_p <= 1'b0;
      if (modem_chg)       mdm_p <= 1'b1;
      else if (rd_msr)     mdm_p <= 1'b0;
    end
  end

  assign iir_rdata = {{(WORD_W-8){1'b0}}, UPPER, code};
  assign irq       = !code[0];
endmodule

module uart_irq_ident_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        line_err,
  input logic        rx_at_level,
  input logic        tx_empty,
  input logic [3:0]  irq_en,
  input logic        rd_lsr,
  input logic        wr_txf,
  input logic [31:0] iir_rdata,
  input logic        irq
);
  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rdata[31:4] == 28'h000000C);
  p_line_shown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |=> (!irq_en[2] || iir_rdata[3:0] == 4'b0110));
  p_line_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lsr && !line_err |=> iir_rdata[3:0] != 4'b0110);
  p_rx_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en[0] && rx_at_level |-> iir_rdata[3:0] inside {4'b0110, 4'b0100, 4'b1100});
  p_tx_write_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txf && !tx_empty |=> iir_rdata[3:0] != 4'b0010);
  p_irq_nint_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !iir_rdata[0]);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_err(line_err), .rx_at_level(rx_at_level),
  .tx_empty(tx_empty), .irq_en(irq_en), .rd_lsr(rd_lsr), .wr_txf(wr_txf),
  .iir_rdata(iir_rdata), .irq(irq)
);

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_err = 0, rx_at_level = 0, rx_timeout = 0, tx_empty = 0, modem_chg = 0;
  logic [3:0] irq_en = 4'hF;
  logic rd_lsr = 0, rd_rxf = 0, rd_iir = 0, wr_txf = 0, rd_msr = 0;
  logic [31:0] iir_rdata;
  logic irq;

  typedef struct {
    logic [31:0] word;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .line_err(line_err), .rx_at_level(rx_at_level),
    .rx_timeout(rx_timeout), .tx_empty(tx_empty), .modem_chg(modem_chg),
    .irq_en(irq_en), .rd_lsr(rd_lsr), .rd_rxf(rd_rxf), .rd_iir(rd_iir),
    .wr_txf(wr_txf), .rd_msr(rd_msr), .iir_rdata(iir_rdata), .irq(irq)
  );

  // ev = {line_err, rx_at_level, rx_timeout, tx_empty, modem_chg}
  // cl = {rd_lsr, rd_rxf, rd_iir, wr_txf, rd_msr}
  // nib = code expected during this cycle
  task automatic step(input logic [4:0] ev, input logic [4:0] cl,
                      input logic [3:0] en, input logic [3:0] nib, input string tag);
    exp_t e;
    @(posedge clk); #1;
    {line_err, rx_at_level, rx_timeout, tx_empty, modem_chg} = ev;
    {rd_lsr, rd_rxf, rd_iir, wr_txf, rd_msr} = cl;
    irq_en = en;
    e.word = {24'h0, 4'hC, nib};
    e.irq  = !nib[0];
    e.tag  = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (iir_rdata !== e.word || irq !== e.irq) begin
        fails++;
        $display("FAIL %s: actual word=%h irq=%b expected word=%h irq=%b",
                 e.tag, iir_rdata, irq, e.word, e.irq);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(5'b00000, 5'b00000, 4'hF, 4'b0001, "R1 reset value");
    step(5'b10000, 5'b00000, 4'hF, 4'b0001, "R4 line event cycle");
    step(5'b00000, 5'b00000, 4'hF, 4'b0110, "R4 line pending");
    step(5'b00000, 5'b10000, 4'hF, 4'b0110, "R4 lsr read cycle");
    step(5'b00000, 5'b00000, 4'hF, 4'b0001, "R4 line cleared");
    step(5'b01000, 5'b00000, 4'hF, 4'b0100, "R5 rx level shown");
    step(5'b01100, 5'b00000, 4'hF, 4'b0100, "R6 timeout pulse cycle");
    step(5'b01000, 5'b00000, 4'hF, 4'b1100, "R6 timeout over rx data");
    step(5'b11000, 5'b00000, 4'hF, 4'b1100, "R6 line event cycle");
    step(5'b01000, 5'b00000, 4'hF, 4'b0110, "R3 line over timeout");
    step(5'b01000, 5'b10000, 4'hF, 4'b0110, "R4 lsr read");
    step(5'b01000, 5'b01000, 4'hF, 4'b1100, "R6 rxf read cycle");
    step(5'b01000, 5'b00000, 4'hF, 4'b0100, "R5 rx data after read");
    step(5'b00000, 5'b00000, 4'hF, 4'b0001, "R5 level dropped");
    step(5'b00010, 5'b00000, 4'hF, 4'b0001, "R7 tx empty rises");
    step(5'b00010, 5'b00000, 4'hF, 4'b0010, "R7 tx latched");
    step(5'b00010, 5'b00010, 4'hF, 4'b0010, "R7 tx write cycle");
    step(5'b00010, 5'b00000, 4'hF, 4'b0001, "R7 tx cleared by write");
    step(5'b00000, 5'b00000, 4'hF, 4'b0001, "R7 tx empty falls");
    step(5'b00010, 5'b00000, 4'hF, 4'b0001, "R7 tx empty rises again");
    step(5'b00011, 5'b00000, 4'hF, 4'b0010, "R9 modem event cycle");
    step(5'b01010, 5'b00000, 4'hF, 4'b0100, "R3 rx over tx");
    step(5'b01010, 5'b00100, 4'hF, 4'b0100, "R8 iir read shows rx");
    step(5'b00010, 5'b00000, 4'hF, 4'b0010, "R8 tx kept pending");
    step(5'b00010, 5'b00100, 4'hF, 4'b0010, "R8 iir read shows tx");
    step(5'b00010, 5'b00000, 4'hF, 4'b0000, "R8 tx cleared, modem shown");
    step(5'b00010, 5'b00001, 4'hF, 4'b0000, "R9 msr read cycle");
    step(5'b00010, 5'b00000, 4'hF, 4'b0001, "R9 modem cleared");
    step(5'b00010, 5'b00000, 4'hD, 4'b0001, "R10 tx masked");
    step(5'b00010, 5'b00000, 4'hD, 4'b0001, "R10 tx masked no latch");
    step(5'b00010, 5'b00000, 4'hF, 4'b0001, "R7 enable rise cycle");
    step(5'b00010, 5'b00000, 4'hF, 4'b0010, "R7 latched on enable rise");
    step(5'b00010, 5'b00000, 4'hD, 4'b0001, "R10 pending tx hidden");
    step(5'b00010, 5'b00010, 4'hD, 4'b0001, "R7 write while masked");
    step(5'b00010, 5'b00000, 4'hF, 4'b0001, "R7 cleared, enable rise");
    step(5'b00010, 5'b00000, 4'hF, 4'b0010, "R7 relatched on enable rise");
    step(5'b00010, 5'b00010, 4'hF, 4'b0010, "R7 write cycle");
    step(5'b00000, 5'b00000, 4'hF, 4'b0001, "R7 cleared");
    step(5'b10000, 5'b00000, 4'hB, 4'b0001, "R10 masked line event");
    step(5'b00000, 5'b00000, 4'hB, 4'b0001, "R10 line hidden");
    step(5'b00000, 5'b00000, 4'hF, 4'b0110, "R10 line kept while masked");
    step(5'b00000, 5'b10000, 4'hF, 4'b0110, "R4 lsr read");
    step(5'b00000, 5'b00000, 4'hF, 4'b0001, "R11 idle irq low");
    step(5'b00001, 5'b00000, 4'hF, 4'b0001, "R9 modem event");
    step(5'b00000, 5'b00000, 4'hF, 4'b0000, "R9 modem shown irq high");
    step(5'b00010, 5'b00000, 4'hF, 4'b0000, "R7 tx rises under modem");
    step(5'b00010, 5'b00000, 4'hF, 4'b0010, "R3 tx over modem");
    step(5'b00010, 5'b00011, 4'hF, 4'b0010, "R2 clear both");
    step(5'b00000, 5'b00000, 4'hF, 4'b0001, "R2 back to idle");
    wait (q.size() == 0);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule